// File: doc/BRIEF.md
# Dual-Mode Host Byte Serializer

This block hands bytes that a receiver front end has recovered to a host controller over a single output wire. Each byte goes out least significant bit first, eight data bits, no parity. Data bytes come from a small upstream buffer through a valid/ready handshake. A higher-priority diagnostic request can also queue a fixed status byte. That byte reports either a working antenna or a failed one.

The transfer mode is picked per byte by a configuration input, which is sampled when the byte is loaded. In asynchronous mode the block times the frame itself from the system clock. A frame is a high start bit, the eight data bits and a low stop bit, and the wire rests low between frames. In synchronous mode the wire goes high to say a byte is waiting. The host then pulls the bits out with falling edges on a separate clock input. Each falling edge puts the next bit on the wire, and the host samples it on the following rising edge. Bits that come from the buffer appear on the wire inverted. The diagnostic codes appear as written.

Top module: `hbs_serializer`

## Requirements
- R1: After reset the output line is low and `data_ready` is high. Whenever `data_ready` is high, the line is low.
- R2: Asynchronous frames have this shape: a start bit driven high, then eight data bits with bit 0 first, then a stop bit driven low. Each bit lasts `BIT_CYCLES` clock cycles (1024 at 16 MHz, that is 15.625 kbaud). The line stays low while idle.
- R3: A data byte taken from the buffer appears on the line bit-inverted. The host therefore decodes `~data_byte`.
- R4: A one-cycle `diag_req` pulse queues a diagnostic byte. From the next cycle until that byte is loaded, `data_ready` is low. A queued diagnostic byte is sent before any waiting data byte.
- R5: The diagnostic byte is decoded as 0xAF when `diag_fail` was 0 at the request, and as 0xFF when it was 1. It is not inverted.
- R6: A byte is accepted only when `data_valid` and `data_ready` are both high at a clock edge. `data_ready` drops in the next cycle and stays low until the current frame has ended. In asynchronous mode the frame ends with its stop bit.
- R7: In synchronous mode, a loaded byte drives the line high, and the line stays high until the first falling edge of `host_clk`.
- R8: In synchronous mode, the k-th falling edge of `host_clk` (k = 1..8) presents data bit k-1 on the line. After the rising edge that follows the eighth falling edge, the line returns low and the block becomes ready again.
- R9: `sync_mode` is sampled only when a byte is loaded. Changing it during a frame does not alter that frame.
- R10: In asynchronous mode, `host_clk` activity has no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1 = host-clocked transfer, 0 = self-timed frame; sampled at load |
| data_valid | input | 1 | Upstream buffer offers a byte |
| data_byte | input | DATA_W | Byte offered by the buffer |
| data_ready | output | 1 | Block accepts the offered byte this cycle |
| diag_req | input | 1 | One-cycle pulse that queues the diagnostic byte |
| diag_fail | input | 1 | Antenna status sampled with `diag_req` (1 = failure) |
| host_clk | input | 1 | Host shift clock for synchronous mode; idles high, falling edge active |
| line_out | output | 1 | Serial wire to the host |

## Verification
The bench builds the block with `BIT_CYCLES` = 16 and `SYNC_STAGES` = 2. The short bit time lets dozens of full asynchronous frames run within the cycle limit. Random bytes are mixed with both modes, and each decoded byte is checked against the bench's own expected value. Directed cases cover the following: a diagnostic request that arrives during a busy frame while data is waiting, both diagnostic codes, a mode flip in mid-frame, and host clock toggling during a self-timed frame.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_A_START = 3'd1,
      ST_A_DATA  = 3'd2,
      ST_A_STOP  = 3'd3,
      ST_S_READY = 3'd4,
      ST_S_SHIFT = 3'd5
   } tx_state_t;

   function automatic logic is_async(input tx_state_t s);
      return (s == ST_A_START) || (s == ST_A_DATA) || (s == ST_A_STOP);
   endfunction

endpackage

// File: rtl/hbs_bit_timer.sv
module hbs_bit_timer #(
   parameter int BIT_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CNT_W = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   assign tick = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/hbs_edge_sync.sv
module hbs_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic fall,
   output logic rise
);
   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= raw_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_in};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[SYNC_STAGES-1];
   end

   assign fall = prev_q && !chain_q[SYNC_STAGES-1];
   assign rise = !prev_q && chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/hbs_source_arb.sv
module hbs_source_arb #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] DIAG_PASS = 8'hAF,
   parameter logic [DATA_W-1:0] DIAG_FAIL = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle,
   input  logic              data_valid,
   input  logic [DATA_W-1:0] data_byte,
   input  logic              diag_req,
   input  logic              diag_fail,
   output logic              data_ready,
   output logic              take,
   output logic [DATA_W-1:0] take_byte
);
   logic pend_q;
   logic fail_q;

   assign data_ready = idle && !pend_q;
   assign take       = idle && (pend_q || data_valid);
   assign take_byte  = pend_q ? (fail_q ? DIAG_FAIL : DIAG_PASS) : ~data_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         fail_q <= 1'b0;
      end else if (diag_req) begin
         pend_q <= 1'b1;
         fail_q <= diag_fail;
      end else if (take && pend_q) begin
         pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/hbs_serializer.sv
module hbs_serializer
   import hbs_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                BIT_CYCLES  = 1024,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] DIAG_PASS   = 8'hAF,
   parameter logic [DATA_W-1:0] DIAG_FAIL   = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_mode,
   input  logic              data_valid,
   input  logic [DATA_W-1:0] data_byte,
   output logic              data_ready,
   input  logic              diag_req,
   input  logic              diag_fail,
   input  logic              host_clk,
   output logic              line_out
);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   generate
      if (DATA_W < 2)      begin : g_bad_w   $error("DATA_W must be at least 2");      end
      if (BIT_CYCLES < 2)  begin : g_bad_bit $error("BIT_CYCLES must be at least 2");  end
      if (SYNC_STAGES < 1) begin : g_bad_syn $error("SYNC_STAGES must be at least 1"); end
   endgenerate

   tx_state_t         state_q;
   logic [DATA_W-1:0] shreg_q;
   logic [IDX_W-1:0]  idx_q;
   logic              line_q;
   logic              bit_tick;
   logic              hfall;
   logic              hrise;
   logic              take;
   logic [DATA_W-1:0] take_byte;

   hbs_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (is_async(state_q)),
      .tick (bit_tick)
   );

   hbs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_hsync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_in(host_clk),
      .fall  (hfall),
      .rise  (hrise)
   );

   hbs_source_arb #(
      .DATA_W   (DATA_W),
      .DIAG_PASS(DIAG_PASS),
      .DIAG_FAIL(DIAG_FAIL)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle      (state_q == ST_IDLE),
      .data_valid(data_valid),
      .data_byte (data_byte),
      .diag_req  (diag_req),
      .diag_fail (diag_fail),
      .data_ready(data_ready),
      .take      (take),
      .take_byte (take_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         shreg_q <= '0;
         idx_q   <= '0;
         line_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               line_q <= 1'b0;
               if (take) begin
                  shreg_q <= take_byte;
                  idx_q   <= '0;
                  line_q  <= 1'b1;
                  state_q <= sync_mode ? ST_S_READY : ST_A_START;
               end
            end
            ST_A_START: begin
               if (bit_tick) begin
                  line_q  <= shreg_q[0];
                  state_q <= ST_A_DATA;
               end
            end
            ST_A_DATA: begin
               if (bit_tick) begin
                  if (idx_q == IDX_LAST) begin
                     line_q  <= 1'b0;
                     state_q <= ST_A_STOP;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     shreg_q <= shreg_q >> 1;
                     line_q  <= shreg_q[1];
                  end
               end
            end
            ST_A_STOP: begin
               line_q <= 1'b0;
               if (bit_tick) state_q <= ST_IDLE;
            end
            ST_S_READY: begin
               if (hfall) begin
                  line_q  <= shreg_q[0];
                  idx_q   <= '0;
                  state_q <= ST_S_SHIFT;
               end
            end
            ST_S_SHIFT: begin
               if (hfall && idx_q != IDX_LAST) begin
                  idx_q   <= idx_q + 1'b1;
                  shreg_q <= shreg_q >> 1;
                  line_q  <= shreg_q[1];
               end else if (hrise && idx_q == IDX_LAST) begin
                  line_q  <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            default: begin
               line_q  <= 1'b0;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign line_out = line_q;
endmodule

// File: rtl/hbs_serializer_chk.sv
module hbs_serializer_chk
   import hbs_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      data_valid,
   input logic      data_ready,
   input logic      diag_req,
   input logic      line_out,
   input tx_state_t state_q,
   input logic      bit_tick
);
   assert_idle_line_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready |-> !line_out);

   assert_data_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bit_tick) && $past(state_q) == ST_A_DATA && state_q == ST_A_DATA) |-> $stable(line_out));

   assert_diag_blocks_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      diag_req |=> !data_ready);

   assert_accept_drops_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid && data_ready) |=> !data_ready);

   assert_sync_ready_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_S_READY) |-> line_out);
endmodule

bind hbs_serializer hbs_serializer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .data_valid(data_valid),
   .data_ready(data_ready),
   .diag_req  (diag_req),
   .line_out  (line_out),
   .state_q   (state_q),
   .bit_tick  (bit_tick)
);

// File: tb/hbs_serializer_tb.sv
module hbs_serializer_tb;
   localparam int NB   = 16;
   localparam int HALF = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_mode = 1'b0;
   logic       data_valid = 1'b0;
   logic [7:0] data_byte = '0;
   logic       data_ready;
   logic       diag_req = 1'b0;
   logic       diag_fail = 1'b0;
   logic       host_clk = 1'b1;
   logic       line_out;

   int vectors = 0;
   int errors  = 0;

   always #2 clk = ~clk;

   hbs_serializer #(.BIT_CYCLES(NB), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
      .data_valid(data_valid), .data_byte(data_byte), .data_ready(data_ready),
      .diag_req(diag_req), .diag_fail(diag_fail),
      .host_clk(host_clk), .line_out(line_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_data(input logic [7:0] b);
      return ~b;
   endfunction

   function automatic logic [7:0] exp_diag(input logic fail);
      return fail ? 8'hFF : 8'hAF;
   endfunction

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      data_valid = 1'b1;
      data_byte  = b;
      while (!data_ready) @(negedge clk);
      @(negedge clk);
      data_valid = 1'b0;
   endtask

   task automatic wait_line_high();
      int n = 0;
      while (!line_out && n < 4000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic decode_async(output logic [7:0] v);
      wait_line_high();
      repeat (NB/2) @(negedge clk);
      chk(line_out == 1'b1, "R2 start bit", line_out, 1);
      for (int i = 0; i < 8; i++) begin
         repeat (NB) @(negedge clk);
         v[i] = line_out;
      end
      repeat (NB) @(negedge clk);
      chk(line_out == 1'b0, "R2 stop bit", line_out, 0);
   endtask

   task automatic decode_sync(output logic [7:0] v);
      wait_line_high();
      repeat (6) @(negedge clk);
      chk(line_out == 1'b1, "R7 ready level held", line_out, 1);
      for (int i = 0; i < 8; i++) begin
         host_clk = 1'b0;
         repeat (HALF) @(negedge clk);
         v[i] = line_out;
         host_clk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      chk(line_out == 1'b0, "R8 line low after byte", line_out, 0);
      chk(data_ready == 1'b1, "R8 ready again", data_ready, 1);
   endtask

   task automatic pulse_diag(input logic fail);
      @(negedge clk);
      diag_req  = 1'b1;
      diag_fail = fail;
      @(negedge clk);
      diag_req  = 1'b0;
      chk(data_ready == 1'b0, "R4 ready low while diag queued", data_ready, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [7:0] b, v;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(line_out == 1'b0, "R1 reset line", line_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(line_out == 1'b0, "R1 idle line", line_out, 0);
      chk(data_ready == 1'b1, "R1 ready after reset", data_ready, 1);

      // R2 R3: directed corner bytes then random, asynchronous
      for (int i = 0; i < 24; i++) begin
         b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'h01 : 8'($urandom);
         sync_mode = 1'b0;
         push(b);
         chk(data_ready == 1'b0, "R6 busy after accept", data_ready, 0);
         decode_async(v);
         chk(v == exp_data(b), "R3 async byte", v, exp_data(b));
      end

      // R6: ready stays low until stop bit has ended
      push(8'h5A);
      decode_async(v);
      chk(data_ready == 1'b0, "R6 ready low mid stop", data_ready, 0);
      repeat (NB) @(negedge clk);
      chk(data_ready == 1'b1, "R6 ready after stop", data_ready, 1);

      // R5: both diagnostic codes, asynchronous
      pulse_diag(1'b0);
      decode_async(v);
      chk(v == exp_diag(1'b0), "R5 diag pass", v, exp_diag(1'b0));
      pulse_diag(1'b1);
      decode_async(v);
      chk(v == exp_diag(1'b1), "R5 diag fail", v, exp_diag(1'b1));

      // R4: diag queued during a busy frame goes ahead of waiting data
      push(8'h3C);
      fork
         begin
            pulse_diag(1'b0);
            push(8'hC5);
         end
         begin
            decode_async(v);
            chk(v == exp_data(8'h3C), "R4 first frame", v, exp_data(8'h3C));
            decode_async(v);
            chk(v == exp_diag(1'b0), "R4 diag before data", v, exp_diag(1'b0));
            decode_async(v);
            chk(v == exp_data(8'hC5), "R4 data after diag", v, exp_data(8'hC5));
         end
      join

      // R9: mode flip mid-frame ignored
      push(8'h96);
      fork
         begin repeat (3*NB) @(negedge clk); sync_mode = 1'b1; end
         decode_async(v);
      join
      sync_mode = 1'b0;
      chk(v == exp_data(8'h96), "R9 mode flip ignored", v, exp_data(8'h96));

      // R10: host clock toggling in async mode
      push(8'h4B);
      fork
         begin
            for (int k = 0; k < 30; k++) begin
               repeat (5) @(negedge clk);
               host_clk = ~host_clk;
            end
            host_clk = 1'b1;
         end
         decode_async(v);
      join
      chk(v == exp_data(8'h4B), "R10 host clock ignored", v, exp_data(8'h4B));
      repeat (4) @(negedge clk);

      // R7 R8: synchronous mode, corner and random bytes
      for (int i = 0; i < 16; i++) begin
         b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'($urandom);
         sync_mode = 1'b1;
         push(b);
         decode_sync(v);
         chk(v == exp_data(b), "R8 sync byte", v, exp_data(b));
      end
      pulse_diag(1'b1);
      decode_sync(v);
      chk(v == exp_diag(1'b1), "R5 sync diag", v, exp_diag(1'b1));

      // mixed modes per byte
      for (int i = 0; i < 8; i++) begin
         b = 8'($urandom);
         sync_mode = i[0];
         push(b);
         if (i[0]) decode_sync(v); else decode_async(v);
         chk(v == exp_data(b), "R9 per-byte mode", v, exp_data(b));
         repeat (NB) @(negedge clk);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule